// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block is a small host-side register window. Through one 32-bit command register it reaches a private space of 8-bit internal registers. The same window also holds a general control register and three interrupt registers: enable mask, write-one-to-clear, and status. In a single host write, software places an internal address, a data byte and a direction flag into the command register. The bridge then carries out the internal access over a fixed number of cycles and shows a busy flag for that whole time. When a read finishes, its result appears in the top byte of the command register.

Software polls busy before it issues a command. For a read, it polls again before it takes the result. A command written while the bridge is busy is dropped, and a sticky error flag records the collision. The control register provides a soft reset and a clock-mode field. The clock-mode field can stall the internal access. The internal register file is a plain memory stub that stands in for the protocol engines behind the window.

Top module: `regwin_bridge`

## Requirements
- R1: After the synchronous reset, the control, command, mask and status registers all read 0, and `irq` is low.
- R2: The command word holds the internal address in [7:0], write data in [15:8], direction in bit 16, a collision error in bit 22, busy in bit 23 and read data in [31:24]. A command with bit 16 = 1 stores byte [15:8] at the internal address. The accepted address, data and direction read back in their fields.
- R3: A command with bit 16 = 0 reads the addressed internal register. Once busy clears, the value is in [31:24] and stays there until the next read completes. Internal addresses 0x00 and 0xFF are both reachable.
- R4: Busy reads 1 on the first ACC_LAT host reads that follow an accepted command write. It reads 0 on the read after those, provided the clock mode is 1 or 2 the whole time.
- R5: A command written while busy is 1 is ignored: the pending access and its fields are unchanged. Bit 22 of the command word then sets and stays set until a soft reset.
- R6: The control register at offset 0x00 holds a soft reset in bit 0 and a clock mode in bits [2:1], and reads back as written. Modes 1 (gated, normal) and 2 (free-running, debug) let an access advance. Modes 0 (off) and 3 hold it busy until a running mode is selected.
- R7: While the soft reset is 1, busy, the error flag, the command fields, the read data and the interrupt status are held at 0, and events and command writes are ignored. `irq` is 0 from the second cycle after the control write that sets the soft reset. The internal registers keep their contents.
- R8: The mask (0x08), clear (0x0C) and status (0x10) registers use bit 1 for transmit and bit 2 for receive. Only those two bits exist in the mask and status registers. Writing 1 to a clear bit clears the matching status bit.
- R9: An event arriving in the same cycle as a clear of its own status bit leaves that bit set.
- R10: `irq` is the OR of status AND mask, registered, one cycle behind the status and mask registers. An event with its mask bit at 0 does not raise `irq`.
- R11: Host reads return data one cycle after `host_rd`. The clear register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | HADDR_W | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| ev_tx | input | 1 | Transmit event pulse |
| ev_rx | input | 1 | Receive event pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the bridge with ACC_LAT = 3 rather than the default of 2. At that value the busy window spans several counter decrements, and the bench can tell a window that is one cycle short or long from a correct one. The widths stay at their defaults of 8-bit internal address and data with a 5-bit host offset. That puts internal addresses 0x00 and 0xFF within reach, and every host offset up to 0x14, including an unmapped one. In this build, clock mode 3 and the collision cases fall inside the busy window, where they can be seen at the ports.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  // field positions inside the command word (decoded by software)
  localparam int F_ADDR_LO = 0;
  localparam int F_WD_LO   = 8;
  localparam int F_WE      = 16;
  localparam int F_ERR     = 22;
  localparam int F_BUSY    = 23;
  localparam int F_RD_LO   = 24;

  // host offsets
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_CMD  = 'h04;
  localparam int OFS_MASK = 'h08;
  localparam int OFS_CLR  = 'h0C;
  localparam int OFS_STAT = 'h10;

  // interrupt vector layout
  localparam int IRQ_W      = 3;
  localparam int IRQ_TX_BIT = 1;
  localparam int IRQ_RX_BIT = 2;
  localparam logic [IRQ_W-1:0] IRQ_IMPL = 3'b110;

  typedef enum logic [1:0] {
    CLK_OFF   = 2'd0,
    CLK_GATED = 2'd1,
    CLK_FREE  = 2'd2,
    CLK_RSVD  = 2'd3
  } clk_mode_e;
endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [2:0] wdata,
  output logic       srst,
  output logic [1:0] mode_bits,
  output logic       clk_en
);
  clk_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      srst   <= 1'b0;
      mode_q <= CLK_OFF;
    end else if (wr) begin
      srst   <= wdata[0];
      mode_q <= clk_mode_e'(wdata[2:1]);
    end
  end

  assign mode_bits = mode_q;
  assign clk_en    = (mode_q == CLK_GATED) || (mode_q == CLK_FREE);

  // R6
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (srst == $past(wdata[0])) && (mode_bits == $past(wdata[2:1])));
endmodule

// File: rtl/regwin_reg_stub.sv
module regwin_reg_stub #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single-port, read-first, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/regwin_cmd_engine.sv
module regwin_cmd_engine #(
  parameter int ACC_LAT = 2,
  parameter int AW      = 8,
  parameter int DW      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic             clk_en,
  input  logic             cmd_wr,
  input  logic [AW+DW:0]   cmd_in,   // {we, wdata, addr}
  output logic             busy,
  output logic             err,
  output logic [AW+DW:0]   cmd_q,
  output logic [DW-1:0]    rd_data,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);
  // the registered memory read needs at least two cycles
  localparam int LAT = (ACC_LAT < 2) ? 2 : ACC_LAT;
  localparam int CW  = $clog2(LAT + 1);

  logic [CW-1:0] cnt;
  logic          accept;
  logic          last;
  logic          we_q;

  assign we_q      = cmd_q[AW+DW];
  assign mem_addr  = cmd_q[AW-1:0];
  assign mem_wdata = cmd_q[AW+DW-1:AW];
  assign accept    = cmd_wr && !busy && !srst;
  assign last      = busy && clk_en && (cnt == CW'(1));
  assign mem_we    = last && we_q;

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      busy    <= 1'b0;
      err     <= 1'b0;
      cnt     <= '0;
      cmd_q   <= '0;
      rd_data <= '0;
    end else begin
      if (accept) begin
        cmd_q <= cmd_in;
        busy  <= 1'b1;
        cnt   <= CW'(LAT);
      end else if (busy && clk_en) begin
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          cnt  <= '0;
          if (!we_q) rd_data <= mem_rdata;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
      if (cmd_wr && busy) err <= 1'b1;
    end
  end

  // R4
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);
  // R5
  collision_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && busy && !srst) |=> err);
  // R5
  collision_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && busy && !srst) |=> $stable(cmd_q));
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err && !srst) |=> err);
  // R6
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !clk_en && !srst) |=> busy);
  // R7
  srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    srst |=> (!busy && !err));
endmodule

// File: rtl/regwin_irq.sv
module regwin_irq #(
  parameter int           W    = 3,
  parameter logic [W-1:0] IMPL = 3'b110
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         srst,
  input  logic         mask_wr,
  input  logic         clr_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] mask,
  output logic [W-1:0] status,
  output logic         irq
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      always_ff @(posedge clk) begin
        if (rst)          mask[i] <= 1'b0;
        else if (mask_wr) mask[i] <= wdata[i];
      end

      always_ff @(posedge clk) begin
        if (rst || srst)                status[i] <= 1'b0;
        else if (evt[i])                status[i] <= 1'b1;
        else if (clr_wr && wdata[i])    status[i] <= 1'b0;
      end

      // R9
      evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (evt[i] && !srst) |=> status[i]);
      // R8
      w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && wdata[i] && !evt[i]) |=> !status[i]);
    end else begin : g_tie
      assign mask[i]   = 1'b0;
      assign status[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= !srst && |(status & mask);
  end

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    srst |=> !irq);
  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!srst && |(status & mask)) |=> irq);
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int HADDR_W = 5,
  parameter int ACC_LAT = 2,
  parameter int IA_W    = 8,
  parameter int ID_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               ev_tx,
  input  logic               ev_rx,
  output logic               irq
);
  localparam int CMD_W = IA_W + ID_W + 1;

  logic ctrl_wr, cmd_wr, mask_wr, clr_wr;
  logic srst, clk_en;
  logic [1:0] mode_bits;
  logic busy, err;
  logic [CMD_W-1:0] cmd_in, cmd_q;
  logic [ID_W-1:0]  rd_data;
  logic             mem_we;
  logic [IA_W-1:0]  mem_addr;
  logic [ID_W-1:0]  mem_wdata, mem_rdata;
  logic [IRQ_W-1:0] evt, mask, status;
  logic [31:0]      cmd_word, rd_mux;

  assign ctrl_wr = host_wr && (host_addr == HADDR_W'(OFS_CTRL));
  assign cmd_wr  = host_wr && (host_addr == HADDR_W'(OFS_CMD));
  assign mask_wr = host_wr && (host_addr == HADDR_W'(OFS_MASK));
  assign clr_wr  = host_wr && (host_addr == HADDR_W'(OFS_CLR));

  assign cmd_in = {host_wdata[F_WE], host_wdata[F_WD_LO +: ID_W], host_wdata[F_ADDR_LO +: IA_W]};

  always_comb begin
    evt             = '0;
    evt[IRQ_TX_BIT] = ev_tx;
    evt[IRQ_RX_BIT] = ev_rx;
  end

  regwin_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr        (ctrl_wr),
    .wdata     (host_wdata[2:0]),
    .srst      (srst),
    .mode_bits (mode_bits),
    .clk_en    (clk_en)
  );

  regwin_cmd_engine #(.ACC_LAT(ACC_LAT), .AW(IA_W), .DW(ID_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .srst      (srst),
    .clk_en    (clk_en),
    .cmd_wr    (cmd_wr),
    .cmd_in    (cmd_in),
    .busy      (busy),
    .err       (err),
    .cmd_q     (cmd_q),
    .rd_data   (rd_data),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  regwin_reg_stub #(.AW(IA_W), .DW(ID_W)) u_stub (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  regwin_irq #(.W(IRQ_W), .IMPL(IRQ_IMPL)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .srst    (srst),
    .mask_wr (mask_wr),
    .clr_wr  (clr_wr),
    .wdata   (host_wdata[IRQ_W-1:0]),
    .evt     (evt),
    .mask    (mask),
    .status  (status),
    .irq     (irq)
  );

  always_comb begin
    cmd_word                     = '0;
    cmd_word[F_ADDR_LO +: IA_W]  = cmd_q[IA_W-1:0];
    cmd_word[F_WD_LO +: ID_W]    = cmd_q[IA_W +: ID_W];
    cmd_word[F_WE]               = cmd_q[CMD_W-1];
    cmd_word[F_ERR]              = err;
    cmd_word[F_BUSY]             = busy;
    cmd_word[F_RD_LO +: ID_W]    = rd_data;
  end

  always_comb begin
    rd_mux = '0;
    if (host_addr == HADDR_W'(OFS_CTRL))      rd_mux[2:0]       = {mode_bits, srst};
    else if (host_addr == HADDR_W'(OFS_CMD))  rd_mux            = cmd_word;
    else if (host_addr == HADDR_W'(OFS_MASK)) rd_mux[IRQ_W-1:0] = mask;
    else if (host_addr == HADDR_W'(OFS_STAT)) rd_mux[IRQ_W-1:0] = status;
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_mux;
  end

  // R6
  run_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !srst && (mode_bits == 2'd0 || mode_bits == 2'd3)) |=> busy);
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/tb_regwin_bridge.sv
module tb_regwin_bridge;
  localparam int TCK = 10;
  localparam int LAT = 3;
  localparam int HW  = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0;
  logic          host_rd = 1'b0;
  logic [HW-1:0] host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          ev_tx = 1'b0;
  logic          ev_rx = 1'b0;
  logic          irq;

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #(TCK/2) clk = ~clk;

  regwin_bridge #(.HADDR_W(HW), .ACC_LAT(LAT)) dut (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .ev_tx      (ev_tx),
    .ev_rx      (ev_rx),
    .irq        (irq)
  );

  function automatic logic [31:0] mkc(input logic [7:0] rd, input logic bsy, input logic er,
                                      input logic we, input logic [7:0] wd, input logic [7:0] a);
    return {rd, bsy, er, 5'b0, we, wd, a};
  endfunction

  function automatic logic [31:0] cw(input logic we, input logic [7:0] wd, input logic [7:0] a);
    return {15'b0, we, wd, a};
  endfunction

  // driver: one cycle of stimulus, applied at the falling edge
  task automatic cyc(input logic wr, input logic rd, input int a, input logic [31:0] d,
                     input logic et, input logic er);
    @(negedge clk);
    host_wr    = wr;
    host_rd    = rd;
    host_addr  = HW'(a);
    host_wdata = d;
    ev_tx      = et;
    ev_rx      = er;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic hwrite(input int a, input logic [31:0] d);
    cyc(1'b1, 1'b0, a, d, 1'b0, 1'b0);
  endtask

  task automatic hread(input int a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sbq.push_back(it);
    cyc(1'b0, 1'b1, a, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic do_cmd(input logic [31:0] w);
    hwrite('h04, w);
    idle(LAT + 1);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as the registered read data appears
  always @(posedge clk) begin
    if (host_rd && !done) begin
      #(TCK/4);
      if (sbq.size() == 0) begin
        n_vec++;
        n_miss++;
        $display("FAIL R11: read result without expectation, actual %08h expected none", host_rdata);
      end else begin
        item_t it;
        it = sbq.pop_front();
        n_vec++;
        if (host_rdata !== it.exp) begin
          n_miss++;
          $display("FAIL %s: actual %08h expected %08h", it.tag, host_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_miss++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk(irq, 1'b0, "R1 irq after reset");
    hread('h00, 32'h0, "R1 ctrl reset");
    hread('h04, 32'h0, "R1 cmd reset");
    hread('h08, 32'h0, "R1 mask reset");
    hread('h10, 32'h0, "R1 status reset");

    // R6 normal gated clock mode
    hwrite('h00, 32'h2);
    hread('h00, 32'h2, "R6 ctrl readback");

    // R4 busy window, R2 write command
    hwrite('h04, cw(1'b1, 8'h5A, 8'h10));
    for (int k = 1; k <= LAT; k++)
      hread('h04, mkc(8'h00, 1'b1, 1'b0, 1'b1, 8'h5A, 8'h10), "R4 busy during access");
    hread('h04, mkc(8'h00, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h10), "R4 busy clear after access");

    // R3 read back
    do_cmd(cw(1'b0, 8'h00, 8'h10));
    hread('h04, mkc(8'h5A, 1'b0, 1'b0, 1'b0, 8'h00, 8'h10), "R3 read addr 0x10");
    do_cmd(cw(1'b1, 8'hA5, 8'hFF));
    hread('h04, mkc(8'h5A, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hFF), "R2 write fields addr 0xFF");
    do_cmd(cw(1'b1, 8'h3C, 8'h00));
    do_cmd(cw(1'b0, 8'h00, 8'hFF));
    hread('h04, mkc(8'hA5, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF), "R3 read addr 0xFF");
    do_cmd(cw(1'b0, 8'h00, 8'h00));
    hread('h04, mkc(8'h3C, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00), "R3 read addr 0x00");

    // R5 collision
    hwrite('h04, cw(1'b1, 8'h11, 8'h20));
    hwrite('h04, cw(1'b1, 8'h77, 8'h20));
    idle(LAT + 1);
    hread('h04, mkc(8'h3C, 1'b0, 1'b1, 1'b1, 8'h11, 8'h20), "R5 collision ignored, error set");
    do_cmd(cw(1'b0, 8'h00, 8'h20));
    hread('h04, mkc(8'h11, 1'b0, 1'b1, 1'b0, 8'h00, 8'h20), "R5 first data kept, error sticky");

    // R6 clock-off and reserved modes stall
    hwrite('h00, 32'h0);
    hread('h00, 32'h0, "R6 ctrl mode off");
    hwrite('h04, cw(1'b0, 8'h00, 8'hFF));
    idle(6);
    hread('h04, mkc(8'h11, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF), "R6 mode 0 stalls");
    hwrite('h00, 32'h4);
    idle(LAT + 1);
    hread('h04, mkc(8'hA5, 1'b0, 1'b1, 1'b0, 8'h00, 8'hFF), "R6 mode 2 completes");
    hwrite('h00, 32'h6);
    hwrite('h04, cw(1'b0, 8'h00, 8'h00));
    idle(6);
    hread('h04, mkc(8'hA5, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00), "R6 mode 3 stalls");
    hwrite('h00, 32'h2);
    idle(LAT + 1);
    hread('h04, mkc(8'h3C, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00), "R6 mode 1 completes");

    // R8 and R10 interrupt mask, status, clear
    hwrite('h08, 32'hFF);
    hread('h08, 32'h6, "R8 mask has only bits 1 and 2");
    cyc(1'b0, 1'b0, 0, 32'h0, 1'b1, 1'b0);
    idle(2);
    chk(irq, 1'b1, "R10 irq on unmasked tx");
    hread('h10, 32'h2, "R8 tx status bit 1");
    hwrite('h0C, 32'h2);
    idle(2);
    chk(irq, 1'b0, "R10 irq drops after clear");
    hread('h10, 32'h0, "R8 write-one clear");
    hread('h0C, 32'h0, "R11 clear register reads 0");
    hread('h14, 32'h0, "R11 unmapped offset reads 0");
    hwrite('h08, 32'h2);
    cyc(1'b0, 1'b0, 0, 32'h0, 1'b0, 1'b1);
    idle(2);
    chk(irq, 1'b0, "R10 masked rx keeps irq low");
    hread('h10, 32'h4, "R8 rx status bit 2");
    hwrite('h08, 32'h4);
    idle(2);
    chk(irq, 1'b1, "R10 irq on unmasking rx");

    // R9 event beats clear
    cyc(1'b0, 1'b0, 0, 32'h0, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 'h0C, 32'h2, 1'b1, 1'b0);
    idle(1);
    hread('h10, 32'h6, "R9 tx event wins over clear");
    cyc(1'b1, 1'b0, 'h0C, 32'h2, 1'b0, 1'b1);
    idle(1);
    hread('h10, 32'h4, "R9 clear of other bit still applies");

    // R7 soft reset
    hwrite('h00, 32'h3);
    idle(2);
    chk(irq, 1'b0, "R7 irq low in soft reset");
    hread('h00, 32'h3, "R6 ctrl soft reset bit");
    hread('h10, 32'h0, "R7 status cleared");
    hread('h04, 32'h0, "R7 command state cleared");
    cyc(1'b1, 1'b0, 'h04, cw(1'b1, 8'h99, 8'h20), 1'b1, 1'b1);
    idle(LAT + 2);
    hread('h10, 32'h0, "R7 events ignored in soft reset");
    hread('h04, 32'h0, "R7 command ignored in soft reset");
    hwrite('h00, 32'h2);
    do_cmd(cw(1'b0, 8'h00, 8'h20));
    hread('h04, mkc(8'h11, 1'b0, 1'b0, 1'b0, 8'h00, 8'h20), "R7 internal registers kept");
    idle(2);
    chk(irq, 1'b0, "R7 irq stays low after release");

    idle(4);
    if (sbq.size() != 0) begin
      n_vec++;
      n_miss++;
      $display("FAIL R11: actual %0d reads unanswered expected 0", sbq.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule